// File: doc/BRIEF.md
# Double-Buffered DAC Code Register

This block holds the code for a 10-bit digital-to-analog converter behind two byte-wide registers on a small read/write bus. The upper register carries code bits 9:2 and the two most significant bits of the lower register carry code bits 1:0, so the code is left-aligned across the pair. The converter never sees these registers directly. It sees a hidden holding register that the bus cannot read or write. The holding register is loaded from the pair only at well-defined moments, so the converter never receives a half-updated code.

There are two load policies. In direct mode, every write to the upper register loads the holding register in the same clock edge. The new upper byte is joined with the lower bits already stored. In event mode, a write only stages the value, and a rising edge on one of eight trigger inputs, picked by a 3-bit selector, performs the load. Software that needs only 8 bits writes the upper register alone. Software that needs 10 bits writes the lower register first and the upper one second. In event mode, a lower-register write blocks any load until the matching upper write arrives.

Top module: `dac_code_buffer`

## Requirements
- R1: After reset, both registers read back zero and `dac_code` is zero.
- R2: The upper register (`bus_sel`=1) stores all 8 written bits, reads them back, and supplies `dac_code[9:2]` when a load takes place.
- R3: The lower register (`bus_sel`=0) stores only written bits 7:6, which supply `dac_code[1:0]`. Its bits 5:0 always read back zero, and writes to them are ignored.
- R4: A write to the lower register never changes `dac_code` by itself, in either mode.
- R5: With `trig_mode_en`=0, a write to the upper register sets `dac_code` one clock later to {written byte, stored lower bits 7:6}.
- R6: With `trig_mode_en`=1, a write to the upper register does not change `dac_code`.
- R7: In event mode, a load happens only on a rising edge of `trig_in[trig_sel]`. Inputs that are not selected have no effect, and holding the selected input high gives only one load.
- R8: After reset in event mode, triggers are ignored until the first write to the upper register.
- R9: A write to the lower register disarms triggered loads until the next write to the upper register, so no mix of old and new code can reach the output.
- R10: Once armed by an upper-register write, every later trigger edge loads the current register contents. This gives the 8-bit mode, which uses repeated loads without any further writes.
- R11: If an upper-register write and a trigger edge fall in the same clock cycle of an armed event mode, the load uses the contents held before that write. The new byte is loaded on the next trigger edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_sel | input | 1 | Register select: 0 lower, 1 upper |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Readback of the selected register |
| trig_mode_en | input | 1 | 1 selects event mode, 0 selects direct mode |
| trig_sel | input | 3 | Index of the trigger input in use |
| trig_in | input | 8 | Trigger inputs |
| dac_code | output | 10 | Holding register value sent to the converter |

## Verification
The checker assumes that `trig_mode_en` and `trig_sel` stay constant around a trigger edge. Switching the selector could look like a rising edge when it moves from a low input to a high one. The checker also assumes that each trigger input and each bus strobe is synchronous to `clk`. The bench meets these assumptions by changing the mode and the selector only while every trigger input is low. It drives all strobes and triggers on the falling clock edge, and it holds each trigger for whole cycles.

// File: rtl/dac_buf_pkg.sv
package dac_buf_pkg;
   typedef enum logic {
      REG_LOWER = 1'b0,
      REG_UPPER = 1'b1
   } dac_reg_e;
endpackage

// File: rtl/dac_byte_regs.sv
module dac_byte_regs #(
   parameter int BYTE_W   = 8,
   parameter int LOW_BITS = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr,
   input  logic                bus_sel,
   input  logic [BYTE_W-1:0]   bus_wdata,
   output logic [BYTE_W-1:0]   upper_q,
   output logic [LOW_BITS-1:0] lower_q,
   output logic                upper_wr,
   output logic                lower_wr,
   output logic [BYTE_W-1:0]   bus_rdata
);
   import dac_buf_pkg::*;

   localparam int PAD_W = BYTE_W - LOW_BITS;

   initial begin
      if (LOW_BITS < 1 || LOW_BITS >= BYTE_W)
         $error("dac_byte_regs: LOW_BITS must be in 1..BYTE_W-1");
   end

   assign upper_wr = bus_wr && (dac_reg_e'(bus_sel) == REG_UPPER);
   assign lower_wr = bus_wr && (dac_reg_e'(bus_sel) == REG_LOWER);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         upper_q <= '0;
         lower_q <= '0;
      end else begin
         if (upper_wr) upper_q <= bus_wdata;
         if (lower_wr) lower_q <= bus_wdata[BYTE_W-1 -: LOW_BITS];
      end
   end

   logic [BYTE_W-1:0] lower_view;

   generate
      if (PAD_W > 0) begin : g_pad
         assign lower_view = {lower_q, {PAD_W{1'b0}}};
      end else begin : g_full
         assign lower_view = lower_q;
      end
   endgenerate

   assign bus_rdata = (dac_reg_e'(bus_sel) == REG_UPPER) ? upper_q : lower_view;
endmodule

// File: rtl/dac_trig_edge.sv
module dac_trig_edge #(
   parameter int TRIG_N = 8,
   parameter int SEL_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TRIG_N-1:0] trig_in,
   input  logic [SEL_W-1:0]  trig_sel,
   output logic              trig_rise
);
   initial begin
      if (TRIG_N < 1) $error("dac_trig_edge: TRIG_N must be positive");
      if (TRIG_N > 1 && (1 << SEL_W) < TRIG_N)
         $error("dac_trig_edge: SEL_W too narrow for TRIG_N");
   end

   logic picked;
   logic picked_d;

   generate
      if (TRIG_N == 1) begin : g_single
         logic unused_sel;
         assign unused_sel = ^trig_sel;
         assign picked = trig_in[0];
      end else begin : g_mux
         always_comb begin
            picked = 1'b0;
            for (int i = 0; i < TRIG_N; i++)
               if (SEL_W'(i) == trig_sel) picked = trig_in[i];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) picked_d <= 1'b0;
      else        picked_d <= picked;
   end

   assign trig_rise = picked & ~picked_d;
endmodule

// File: rtl/dac_commit_ctl.sv
module dac_commit_ctl #(
   parameter int BYTE_W   = 8,
   parameter int LOW_BITS = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       trig_mode_en,
   input  logic                       upper_wr,
   input  logic                       lower_wr,
   input  logic [BYTE_W-1:0]          bus_wdata,
   input  logic [BYTE_W-1:0]          upper_q,
   input  logic [LOW_BITS-1:0]        lower_q,
   input  logic                       trig_rise,
   output logic                       armed,
   output logic                       fire,
   output logic [BYTE_W+LOW_BITS-1:0] dac_code
);
   assign fire = trig_mode_en && armed && trig_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        armed <= 1'b0;
      else if (upper_wr) armed <= 1'b1;
      else if (lower_wr) armed <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         dac_code <= '0;
      else if (!trig_mode_en && upper_wr)
         dac_code <= {bus_wdata, lower_q};
      else if (fire)
         dac_code <= {upper_q, lower_q};
   end
endmodule

// File: rtl/dac_code_buffer.sv
module dac_code_buffer #(
   parameter int CODE_W = 10,
   parameter int BYTE_W = 8,
   parameter int TRIG_N = 8,
   localparam int SEL_W = (TRIG_N > 1) ? $clog2(TRIG_N) : 1,
   localparam int LOW_BITS = CODE_W - BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_sel,
   input  logic [BYTE_W-1:0] bus_wdata,
   output logic [BYTE_W-1:0] bus_rdata,
   input  logic              trig_mode_en,
   input  logic [SEL_W-1:0]  trig_sel,
   input  logic [TRIG_N-1:0] trig_in,
   output logic [CODE_W-1:0] dac_code
);
   initial begin
      if (CODE_W <= BYTE_W || CODE_W >= 2 * BYTE_W)
         $error("dac_code_buffer: CODE_W must lie strictly between BYTE_W and 2*BYTE_W");
   end

   logic [BYTE_W-1:0]   upper_q;
   logic [LOW_BITS-1:0] lower_q;
   logic                upper_wr;
   logic                lower_wr;
   logic                trig_rise;
   logic                armed;
   logic                fire;

   dac_byte_regs #(.BYTE_W(BYTE_W), .LOW_BITS(LOW_BITS)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
      .bus_wdata(bus_wdata), .upper_q(upper_q), .lower_q(lower_q),
      .upper_wr(upper_wr), .lower_wr(lower_wr), .bus_rdata(bus_rdata)
   );

   dac_trig_edge #(.TRIG_N(TRIG_N), .SEL_W(SEL_W)) u_edge (
      .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .trig_sel(trig_sel),
      .trig_rise(trig_rise)
   );

   dac_commit_ctl #(.BYTE_W(BYTE_W), .LOW_BITS(LOW_BITS)) u_commit (
      .clk(clk), .rst_n(rst_n), .trig_mode_en(trig_mode_en),
      .upper_wr(upper_wr), .lower_wr(lower_wr), .bus_wdata(bus_wdata),
      .upper_q(upper_q), .lower_q(lower_q), .trig_rise(trig_rise),
      .armed(armed), .fire(fire), .dac_code(dac_code)
   );
endmodule

// File: rtl/dac_code_buffer_chk.sv
module dac_code_buffer_chk #(
   parameter int CODE_W = 10,
   parameter int BYTE_W = 8
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       bus_wr,
   input logic                       bus_sel,
   input logic [BYTE_W-1:0]          bus_wdata,
   input logic [BYTE_W-1:0]          bus_rdata,
   input logic                       trig_mode_en,
   input logic [BYTE_W-1:0]          upper_q,
   input logic [CODE_W-BYTE_W-1:0]   lower_q,
   input logic                       armed,
   input logic                       fire,
   input logic [CODE_W-1:0]          dac_code
);
   localparam int PAD_W = 2 * BYTE_W - CODE_W;

   p_lower_pad_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_sel |-> bus_rdata[PAD_W-1:0] == '0);

   p_lower_write_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bus_sel && !fire) |=> $stable(dac_code));

   p_direct_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!trig_mode_en && bus_wr && bus_sel)
      |=> dac_code == {$past(bus_wdata), $past(lower_q)});

   p_event_no_fire_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_mode_en && !fire) |=> $stable(dac_code));

   p_unarmed_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_mode_en && !armed) |=> $stable(dac_code));

   p_lower_disarms_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bus_sel) |=> !armed);

   p_fire_loads_r10: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> dac_code == {$past(upper_q), $past(lower_q)});
endmodule

bind dac_code_buffer dac_code_buffer_chk #(.CODE_W(CODE_W), .BYTE_W(BYTE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .trig_mode_en(trig_mode_en),
   .upper_q(upper_q), .lower_q(lower_q), .armed(armed), .fire(fire),
   .dac_code(dac_code)
);

// File: tb/dac_code_buffer_test.sv
`timescale 1ns/1ps
module dac_code_buffer_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic       bus_sel = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       trig_mode_en = 1'b0;
   logic [2:0] trig_sel = '0;
   logic [7:0] trig_in = '0;
   logic [9:0] dac_code;

   int total = 0;
   int bad = 0;

   always #2.5 clk = ~clk;

   dac_code_buffer uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .trig_mode_en(trig_mode_en),
      .trig_sel(trig_sel), .trig_in(trig_in), .dac_code(dac_code)
   );

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      trig_in = '0; bus_wr = 1'b0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input logic sel, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_sel = sel; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic sel, output logic [7:0] d);
      @(negedge clk);
      bus_sel = sel;
      #1 d = bus_rdata;
   endtask

   task automatic pulse(input int idx);
      @(negedge clk);
      trig_in[idx] = 1'b1;
      @(negedge clk);
      trig_in = '0;
   endtask

   task automatic t_reset();
      logic [7:0] d;
      do_reset();
      rd(1'b1, d); chk("R1 upper after reset", 16'(d), 16'h00);
      rd(1'b0, d); chk("R1 lower after reset", 16'(d), 16'h00);
      chk("R1 code after reset", 16'(dac_code), 16'h000);
   endtask

   task automatic t_readback();
      logic [7:0] d;
      do_reset();
      trig_mode_en = 1'b1;
      wr(1'b1, 8'h5A);
      rd(1'b1, d); chk("R2 upper readback", 16'(d), 16'h5A);
      wr(1'b0, 8'hFF);
      rd(1'b0, d); chk("R3 lower keeps 7:6 only", 16'(d), 16'hC0);
      wr(1'b0, 8'h7F);
      rd(1'b0, d); chk("R3 lower bits 5:0 ignored", 16'(d), 16'h40);
   endtask

   task automatic t_direct();
      do_reset();
      trig_mode_en = 1'b0;
      wr(1'b0, 8'h80);
      chk("R4 lower write alone", 16'(dac_code), 16'h000);
      wr(1'b1, 8'hC3);
      chk("R5 direct load", 16'(dac_code), 16'({8'hC3, 2'b10}));
      wr(1'b0, 8'h40);
      chk("R4 lower write direct mode", 16'(dac_code), 16'({8'hC3, 2'b10}));
      wr(1'b1, 8'h12);
      chk("R5 direct load new lower", 16'(dac_code), 16'({8'h12, 2'b01}));
   endtask

   task automatic t_unarmed();
      do_reset();
      trig_mode_en = 1'b1; trig_sel = 3'd4;
      pulse(4);
      chk("R8 trigger before any write", 16'(dac_code), 16'h000);
      wr(1'b0, 8'hC0);
      pulse(4);
      chk("R8 trigger after lower write only", 16'(dac_code), 16'h000);
      wr(1'b1, 8'hA5);
      chk("R6 upper write in event mode", 16'(dac_code), 16'h000);
      pulse(4);
      chk("R2 trigger loads upper byte", 16'(dac_code), 16'({8'hA5, 2'b11}));
   endtask

   task automatic t_select();
      do_reset();
      trig_mode_en = 1'b1; trig_sel = 3'd2;
      wr(1'b1, 8'h33);
      pulse(5);
      chk("R7 unselected input ignored", 16'(dac_code), 16'h000);
      @(negedge clk); trig_in[2] = 1'b1;
      @(negedge clk);
      chk("R7 selected rising edge", 16'(dac_code), 16'({8'h33, 2'b00}));
      bus_wr = 1'b1; bus_sel = 1'b1; bus_wdata = 8'h66;
      @(negedge clk); bus_wr = 1'b0;
      repeat (2) @(negedge clk);
      chk("R7 held level no reload", 16'(dac_code), 16'({8'h33, 2'b00}));
      trig_in = '0;
      pulse(2);
      chk("R7 next edge reloads", 16'(dac_code), 16'({8'h66, 2'b00}));
   endtask

   task automatic t_eight_bit();
      do_reset();
      trig_mode_en = 1'b1; trig_sel = 3'd7;
      wr(1'b1, 8'h81);
      pulse(7);
      chk("R10 first load", 16'(dac_code), 16'({8'h81, 2'b00}));
      wr(1'b1, 8'h18);
      pulse(7);
      chk("R10 second load", 16'(dac_code), 16'({8'h18, 2'b00}));
      pulse(7);
      chk("R10 repeat load same value", 16'(dac_code), 16'({8'h18, 2'b00}));
   endtask

   task automatic t_disarm();
      do_reset();
      trig_mode_en = 1'b1; trig_sel = 3'd0;
      wr(1'b1, 8'hF0);
      pulse(0);
      chk("R9 armed load", 16'(dac_code), 16'({8'hF0, 2'b00}));
      wr(1'b0, 8'hC0);
      pulse(0);
      chk("R9 lower write disarms", 16'(dac_code), 16'({8'hF0, 2'b00}));
      wr(1'b1, 8'h0F);
      pulse(0);
      chk("R9 rearmed full code", 16'(dac_code), 16'({8'h0F, 2'b11}));
   endtask

   task automatic t_coincide();
      do_reset();
      trig_mode_en = 1'b1; trig_sel = 3'd1;
      wr(1'b0, 8'h40);
      wr(1'b1, 8'h11);
      @(negedge clk);
      bus_wr = 1'b1; bus_sel = 1'b1; bus_wdata = 8'hEE; trig_in[1] = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; trig_in = '0;
      chk("R11 same cycle uses prior value", 16'(dac_code), 16'({8'h11, 2'b01}));
      pulse(1);
      chk("R11 next edge loads new value", 16'(dac_code), 16'({8'hEE, 2'b01}));
   endtask

   initial begin
      #(5.0 * 100000);
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      t_reset();
      t_readback();
      t_direct();
      t_unarmed();
      t_select();
      t_eight_bit();
      t_disarm();
      t_coincide();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule